// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block drives the row strobe, column strobe, write enable and output enable of an asynchronous DRAM whenever the memory is not being used for data transfer. After reset it keeps every strobe high for a start-up pause. It then runs a fixed number of initialisation cycles back to back and flags that the memory is ready. From then on it owes the memory one refresh per refresh interval. Each owed refresh is carried out as a column-before-row cycle, so the device's internal row counter picks the row and no address or data is involved.

The sequencer shares the strobes with an access controller through a hold request and a hold acknowledge. An owed refresh waits for the acknowledge, so the access controller can postpone refreshes during long bursts. Once the maximum number of postponed refreshes is owed, the sequencer starts the cycle without waiting. On request it also places the memory in self-refresh. It keeps the row strobe low past the entry time and reports when the mode is reached. On release it holds both strobes high for the exit precharge time and then resumes its distributed schedule from zero, with no catch-up burst.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and for PAUSE_CYC clock cycles after it is released, every strobe output is high, `init_done_o` and `hold_req_o` are low, and `bus_release_o` is high.
- R2: After the pause, exactly INIT_CYC refresh cycles run back to back. `init_done_o` then rises and stays high until the next reset. Before it rises, neither `hold_req_o` nor `self_refresh_active_o` is high.
- R3: Every cycle the block drives is column-before-row. CAS# goes low T_CSR cycles before RAS# falls. RAS# stays low T_RAS cycles. Both strobes then stay high for T_RP cycles.
- R4: `we_no` and `oe_no` are held high at all times, so the memory never drives data during a cycle issued by this block.
- R5: After initialisation, one refresh becomes owed every REF_INT cycles. `hold_req_o` is high while a refresh is owed, while `sr_req_i` is high, or while the block is running a cycle.
- R6: An owed refresh starts only while `hold_ack_i` is high, unless MAX_PEND refreshes are owed. In that case it starts without the acknowledge.
- R7: `bus_release_o` is high exactly while the block owns the strobes: during the pause, the initialisation and refresh cycles, self-refresh and its exit.
- R8: With nothing owed, `sr_req_i` and `hold_ack_i` both high start self-refresh. RAS# and CAS# then stay low, and `self_refresh_active_o` rises after T_RASS cycles of low RAS#. A single-cycle request still holds RAS# low for T_RASS+1 cycles.
- R9: When `sr_req_i` falls in self-refresh, `self_refresh_active_o` falls. Both strobes stay high for T_RPS cycles. The owed count restarts from zero, so no refresh is issued for REF_INT cycles.
- R10: When a refresh is owed and self-refresh is requested, the refresh is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_ack_i | input | 1 | Access controller has released the strobes |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| bus_release_o | output | 1 | Sequencer owns the strobes; data bus must float |
| init_done_o | output | 1 | Power-up sequence finished |
| hold_req_o | output | 1 | Sequencer needs or holds the strobes |
| self_refresh_active_o | output | 1 | Memory is in self-refresh |

## Verification
The bench builds the block with a 20-cycle pause, eight initialisation cycles, a 40-cycle refresh interval, T_CSR 2, T_RAS 4, T_RP 3, T_RASS 10, T_RPS 6 and at most three postponed refreshes. With these values the whole power-up sequence, several refresh intervals, the saturation of the postponed count and the forced refresh all fall within a few hundred cycles. A 10-cycle entry time makes it possible to compare a single-cycle self-refresh request against a long one. The 40-cycle interval leaves room to show that no refresh follows self-refresh exit too early, and to set up a refresh owed at the same time as a self-refresh request.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_CSR,
    ST_RAS,
    ST_RP,
    ST_IDLE,
    ST_SR_HOLD,
    ST_SR_EXIT
  } seq_st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int unsigned REF_INT  = 3900,
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic take_i,
  output logic owed_o,
  output logic full_o
);
  localparam int unsigned IW = $clog2(REF_INT + 1);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [IW-1:0] IVL_LAST = IW'(REF_INT - 1);
  localparam logic [PW-1:0] PEND_TOP = PW'(MAX_PEND);

  logic [IW-1:0] ivl_q;
  logic [PW-1:0] pend_q;
  logic          tick;

  assign tick = run_i && (ivl_q == IVL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= '0;
    end else if (!run_i || tick) begin
      ivl_q <= '0;
    end else begin
      ivl_q <= ivl_q + 1'b1;
    end
  end

  // owed refreshes, saturating at the postpone limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (clear_i) begin
      pend_q <= '0;
    end else if (tick && !take_i) begin
      if (pend_q != PEND_TOP) pend_q <= pend_q + 1'b1;
    end else if (take_i && !tick) begin
      pend_q <= pend_q - 1'b1;
    end
  end

  assign owed_o = (pend_q != '0);
  assign full_o = (pend_q == PEND_TOP);
endmodule

// File: rtl/dram_cyc_fsm.sv
module dram_cyc_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 50000,
  parameter int unsigned INIT_CYC  = 8,
  parameter int unsigned T_CSR     = 2,
  parameter int unsigned T_RAS     = 13,
  parameter int unsigned T_RP      = 8,
  parameter int unsigned T_RASS    = 25000,
  parameter int unsigned T_RPS     = 23
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    hold_ack_i,
  input  logic    sr_req_i,
  input  logic    owed_i,
  input  logic    full_i,
  output seq_st_e state_o,
  output logic    init_done_o,
  output logic    sr_cyc_o,
  output logic    take_o,
  output logic    sr_active_o
);
  localparam int unsigned TMAX = max2(max2(max2(PAUSE_CYC, T_CSR), max2(T_RAS, T_RP)),
                                      max2(T_RASS, T_RPS));
  localparam int unsigned CW = $clog2(TMAX + 1);
  localparam int unsigned IW = $clog2(INIT_CYC + 1);
  localparam logic [CW-1:0] L_PAUSE = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] L_CSR   = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_RAS   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RASS  = CW'(T_RASS);
  localparam logic [CW-1:0] L_RPS   = CW'(T_RPS - 1);
  localparam logic [IW-1:0] L_INIT  = IW'(INIT_CYC - 1);

  seq_st_e       state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] icnt_q;
  logic          done_q;
  logic          srm_q;
  logic          commit_ref;
  logic          commit_sr;

  assign commit_ref = (state_q == ST_IDLE) && owed_i && (hold_ack_i || full_i);
  assign commit_sr  = (state_q == ST_IDLE) && !owed_i && sr_req_i && hold_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      cnt_q   <= '0;
      icnt_q  <= '0;
      done_q  <= 1'b0;
      srm_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_PAUSE: begin
          if (cnt_q == L_PAUSE) begin
            state_q <= ST_CSR;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CSR: begin
          if (cnt_q == L_CSR) begin
            state_q <= srm_q ? ST_SR_HOLD : ST_RAS;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RAS: begin
          if (cnt_q == L_RAS) begin
            state_q <= ST_RP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RP: begin
          if (cnt_q == L_RP) begin
            cnt_q <= '0;
            if (done_q) begin
              state_q <= ST_IDLE;
            end else if (icnt_q == L_INIT) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              icnt_q  <= icnt_q + 1'b1;
              state_q <= ST_CSR;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_IDLE: begin
          if (commit_ref) begin
            state_q <= ST_CSR;
          end else if (commit_sr) begin
            state_q <= ST_CSR;
            srm_q   <= 1'b1;
          end
        end
        ST_SR_HOLD: begin
          // cnt saturates at the entry time; exit only after it
          if (cnt_q != L_RASS) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (!sr_req_i) begin
            state_q <= ST_SR_EXIT;
            cnt_q   <= '0;
          end
        end
        ST_SR_EXIT: begin
          if (cnt_q == L_RPS) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            srm_q   <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign state_o     = state_q;
  assign init_done_o = done_q;
  assign sr_cyc_o    = srm_q;
  assign take_o      = commit_ref;
  assign sr_active_o = (state_q == ST_SR_HOLD) && (cnt_q == L_RASS);
endmodule

// File: rtl/dram_pin_enc.sv
module dram_pin_enc
  import dram_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  seq_st_e state_i,
  output logic    ras_no,
  output logic    cas_no,
  output logic    we_no,
  output logic    oe_no,
  output logic    rel_o
);
  logic ras_d;
  logic cas_d;
  logic rel_d;

  always_comb begin
    ras_d = !((state_i == ST_RAS) || (state_i == ST_SR_HOLD));
    cas_d = !((state_i == ST_CSR) || (state_i == ST_RAS) || (state_i == ST_SR_HOLD));
    rel_d = (state_i != ST_IDLE);
  end

  // registered strobes: no decode glitches reach the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_no <= 1'b1;
      cas_no <= 1'b1;
      we_no  <= 1'b1;
      oe_no  <= 1'b1;
      rel_o  <= 1'b1;
    end else begin
      ras_no <= ras_d;
      cas_no <= cas_d;
      we_no  <= 1'b1;
      oe_no  <= 1'b1;
      rel_o  <= rel_d;
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 50000,
  parameter int unsigned INIT_CYC  = 8,
  parameter int unsigned REF_INT   = 3900,
  parameter int unsigned MAX_PEND  = 8,
  parameter int unsigned T_CSR     = 2,
  parameter int unsigned T_RAS     = 13,
  parameter int unsigned T_RP      = 8,
  parameter int unsigned T_RASS    = 25000,
  parameter int unsigned T_RPS     = 23
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_ack_i,
  input  logic sr_req_i,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic oe_no,
  output logic bus_release_o,
  output logic init_done_o,
  output logic hold_req_o,
  output logic self_refresh_active_o
);
  seq_st_e state;
  logic    done;
  logic    sr_cyc;
  logic    take;
  logic    owed;
  logic    full;

  dram_ref_sched #(
    .REF_INT (REF_INT),
    .MAX_PEND(MAX_PEND)
  ) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (done && !sr_cyc),
    .clear_i(sr_cyc),
    .take_i (take),
    .owed_o (owed),
    .full_o (full)
  );

  dram_cyc_fsm #(
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_CYC (INIT_CYC),
    .T_CSR    (T_CSR),
    .T_RAS    (T_RAS),
    .T_RP     (T_RP),
    .T_RASS   (T_RASS),
    .T_RPS    (T_RPS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_ack_i (hold_ack_i),
    .sr_req_i   (sr_req_i),
    .owed_i     (owed),
    .full_i     (full),
    .state_o    (state),
    .init_done_o(done),
    .sr_cyc_o   (sr_cyc),
    .take_o     (take),
    .sr_active_o(self_refresh_active_o)
  );

  dram_pin_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .ras_no (ras_no),
    .cas_no (cas_no),
    .we_no  (we_no),
    .oe_no  (oe_no),
    .rel_o  (bus_release_o)
  );

  assign init_done_o = done;
  assign hold_req_o  = done && (owed || sr_req_i || (state != ST_IDLE));
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_no,
  input logic cas_no,
  input logic bus_release_o,
  input logic init_done_o,
  input logic hold_req_o,
  input logic self_refresh_active_o
);
  a_r3_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (!cas_no && $past(!cas_no)));

  a_r7_release_while_strobing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no || !cas_no) |-> bus_release_o);

  a_r2_done_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r2_quiet_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (!self_refresh_active_o && !hold_req_o));

  a_r8_sr_strobes_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_refresh_active_o |-> (!ras_no && !cas_no));

  a_r9_exit_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(self_refresh_active_o) |=> (ras_no && cas_no));

  a_r5_hold_while_row_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && !ras_no) |-> hold_req_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
  .clk_i                (clk_i),
  .rst_ni               (rst_ni),
  .ras_no               (ras_no),
  .cas_no               (cas_no),
  .bus_release_o        (bus_release_o),
  .init_done_o          (init_done_o),
  .hold_req_o           (hold_req_o),
  .self_refresh_active_o(self_refresh_active_o)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int PAUSE_CYC = 20;
  localparam int INIT_CYC  = 8;
  localparam int REF_INT   = 40;
  localparam int MAX_PEND  = 3;
  localparam int T_CSR     = 2;
  localparam int T_RAS     = 4;
  localparam int T_RP      = 3;
  localparam int T_RASS    = 10;
  localparam int T_RPS     = 6;

  localparam int PH_PAUSE = 0, PH_CSR = 1, PH_RAS = 2, PH_RP = 3,
                 PH_IDLE = 4, PH_SRH = 5, PH_SREX = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0;
  logic sr = 1'b0;
  logic ras_no, cas_no, we_no, oe_no, rel, done_o, hold, sra;

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC), .REF_INT(REF_INT),
    .MAX_PEND(MAX_PEND), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_ack_i(ack), .sr_req_i(sr),
    .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no), .oe_no(oe_no),
    .bus_release_o(rel), .init_done_o(done_o), .hold_req_o(hold),
    .self_refresh_active_o(sra)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ph, m_n, m_icnt, m_pend, m_ivl;
  bit m_done, m_srm, m_run, m_tick, m_take, m_ndone, m_nsrm;
  bit e_ras, e_cas, e_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = PH_PAUSE; m_n = 0; m_icnt = 0; m_pend = 0; m_ivl = 0;
      m_done = 0; m_srm = 0; e_ras = 1; e_cas = 1; e_rel = 1;
    end else begin
      e_ras = !(m_ph == PH_RAS || m_ph == PH_SRH);
      e_cas = !(m_ph == PH_CSR || m_ph == PH_RAS || m_ph == PH_SRH);
      e_rel = (m_ph != PH_IDLE);
      m_run = m_done && !m_srm;
      m_tick = m_run && (m_ivl == REF_INT - 1);
      m_take = 0; m_ndone = m_done; m_nsrm = m_srm;
      case (m_ph)
        PH_PAUSE: if (m_n == PAUSE_CYC - 1) begin m_ph = PH_CSR; m_n = 0; end else m_n++;
        PH_CSR:   if (m_n == T_CSR - 1) begin m_ph = m_srm ? PH_SRH : PH_RAS; m_n = 0; end else m_n++;
        PH_RAS:   if (m_n == T_RAS - 1) begin m_ph = PH_RP; m_n = 0; end else m_n++;
        PH_RP: begin
          if (m_n == T_RP - 1) begin
            m_n = 0;
            if (m_done) m_ph = PH_IDLE;
            else if (m_icnt == INIT_CYC - 1) begin m_ndone = 1; m_ph = PH_IDLE; end
            else begin m_icnt++; m_ph = PH_CSR; end
          end else m_n++;
        end
        PH_IDLE: begin
          if (m_pend > 0 && (ack || m_pend == MAX_PEND)) begin m_take = 1; m_ph = PH_CSR; end
          else if (sr && ack) begin m_nsrm = 1; m_ph = PH_CSR; end
        end
        PH_SRH: if (m_n != T_RASS) m_n++; else if (!sr) begin m_ph = PH_SREX; m_n = 0; end
        PH_SREX: if (m_n == T_RPS - 1) begin m_ph = PH_IDLE; m_n = 0; m_nsrm = 0; end else m_n++;
        default: m_ph = PH_IDLE;
      endcase
      if (m_srm) m_pend = 0;
      else if (m_tick && !m_take) begin if (m_pend < MAX_PEND) m_pend++; end
      else if (m_take && !m_tick) m_pend--;
      if (!m_run || m_tick) m_ivl = 0; else m_ivl++;
      m_done = m_ndone; m_srm = m_nsrm;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(ras_no === e_ras, "R3 ras_no", int'(ras_no), int'(e_ras));
      chk(cas_no === e_cas, "R3 cas_no", int'(cas_no), int'(e_cas));
      chk(we_no === 1'b1 && oe_no === 1'b1, "R4 we/oe", int'({we_no, oe_no}), 3);
      chk(rel === e_rel, "R7 bus_release", int'(rel), int'(e_rel));
      chk(done_o === m_done, "R2 init_done", int'(done_o), int'(m_done));
      chk(hold === (m_done && (m_pend > 0 || sr || m_ph != PH_IDLE)), "R5 hold_req",
          int'(hold), int'(m_done && (m_pend > 0 || sr || m_ph != PH_IDLE)));
      chk(sra === (m_ph == PH_SRH && m_n == T_RASS), "R8 sr_active",
          int'(sra), int'(m_ph == PH_SRH && m_n == T_RASS));
    end
  end

  int ras_falls = 0;
  bit ras_prev = 1'b1;
  always @(negedge clk) begin
    if (ras_prev && ras_no === 1'b0) ras_falls++;
    ras_prev = (ras_no !== 1'b0);
  end

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic low_len(output int len);
    while (ras_no) @(negedge clk);
    len = 0;
    while (!ras_no) begin len++; @(negedge clk); end
  endtask

  task automatic finish_run();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int f0, len;
    tick_n(3);
    // R1 reset state
    chk(ras_no && cas_no && rel && !done_o && !hold && !sra, "R1 reset state",
        int'({ras_no, cas_no, rel, done_o, hold, sra}), 6'b111000);
    @(negedge clk); rst_n = 1'b1;
    // R1 pause: no strobe activity
    for (int i = 0; i < PAUSE_CYC; i++) begin
      @(negedge clk);
      chk(cas_no && ras_no && !done_o, "R1 pause quiet", int'({cas_no, ras_no}), 3);
    end
    while (!done_o) @(negedge clk);
    chk(ras_falls == INIT_CYC, "R2 init cycle count", ras_falls, INIT_CYC);
    #1;
    // R5 regular refresh with acknowledge granted
    ack = 1'b1; f0 = ras_falls;
    tick_n(190);
    chk(ras_falls - f0 == 4, "R5 refreshes per window", ras_falls - f0, 4);
    // R6 postponement then forced refresh
    ack = 1'b0; f0 = ras_falls;
    tick_n(75);
    chk(ras_falls == f0, "R6 postponed without ack", ras_falls - f0, 0);
    f0 = ras_falls;
    tick_n(325);
    chk(ras_falls - f0 > 0, "R6 forced at limit", ras_falls - f0, 1);
    ack = 1'b1;
    tick_n(30);
    // R8 self-refresh entry
    sr = 1'b1;
    for (int i = 0; i < 60 && !sra; i++) @(negedge clk);
    chk(sra === 1'b1, "R8 sr reached", int'(sra), 1);
    tick_n(50);
    chk(!ras_no && !cas_no && sra, "R8 sr held", int'({ras_no, cas_no}), 0);
    sr = 1'b0;
    while (sra) @(negedge clk);
    tick_n(T_RPS + 2);
    chk(ras_no && cas_no && !hold, "R9 exit idle", int'({ras_no, cas_no, hold}), 6);
    f0 = ras_falls;
    tick_n(30);
    chk(ras_falls == f0, "R9 no burst after exit", ras_falls - f0, 0);
    // R8 short request still holds the entry time
    sr = 1'b1; tick_n(2); sr = 1'b0;
    low_len(len);
    chk(len == T_RASS + 1, "R8 short request low time", len, T_RASS + 1);
    #1;
    // R10 owed refresh before self-refresh
    ack = 1'b0; sr = 1'b1;
    tick_n(60);
    chk(hold === 1'b1, "R10 hold while waiting", int'(hold), 1);
    ack = 1'b1;
    low_len(len);
    chk(len == T_RAS, "R10 refresh first", len, T_RAS);
    #1;
    tick_n(40);
    sr = 1'b0;
    tick_n(40);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule